// File: doc/BRIEF.md
# Low-Rate Clock Edge Noise-Window Qualifier

This block watches a low-rate input clock running at 2, 4 or 8 kHz and decides, edge by edge, whether that clock is clean enough to be offered for clock selection. A reference-domain tick strobe serves as the timebase. The block counts these ticks between successive input edges. It compares each measured interval against a tolerance window of plus or minus five percent around the nominal period for the selected rate. One edge outside the window withdraws qualification, and one edge inside the window restores it. A missing edge also withdraws qualification once the upper bound of the window has passed.

The input edge strobe and the reference tick arrive as single-cycle pulses that are already synchronous to `clk`. An enable input gates the whole function. While the enable is low, or while the rate code names no low-rate clock, the block reports the input as qualified. The downstream selection logic reads `qualified` as one of its eligibility conditions.

Top module: `edge_noise_qualifier`

## Requirements
- R1: After reset `qualified` is 1 and no measurement is running.
- R2: `rate_sel` code 0 selects 2 kHz, code 1 selects 4 kHz and code 2 selects 8 kHz. The nominal period P in reference ticks is REF_TICK_HZ divided by the rate, and the window is the closed range [P - floor(P/20), P + floor(P/20)]. With the default REF_TICK_HZ of 80000 the windows are [38,42], [19,21] and [10,10].
- R3: When a measurement is running, an edge whose tick count lies outside the window drives `qualified` to 0 in the cycle after the edge.
- R4: When a measurement is running, an edge whose tick count lies inside the window drives `qualified` to 1 in the cycle after the edge.
- R5: The tick count is the number of ticks since the previous edge, and it restarts on every edge. A tick that arrives in the same cycle as an edge counts toward the new interval and not the old one.
- R6: If the count passes the upper bound with no edge, `qualified` falls in the cycle after the tick that took it past the bound. The count then holds, and a later in-window interval requalifies the input.
- R7: While `win_en` is 0, `qualified` is 1 whatever the edges do, and the internal verdict returns to qualified.
- R8: The first edge after reset, after `win_en` rises or after a change of `rate_sel` only starts a measurement and leaves `qualified` unchanged.
- R9: `rate_sel` code 3 marks an input that is not a low-rate clock. The check does not apply, and `qualified` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle reference timebase strobe |
| edge_stb | input | 1 | One-cycle strobe per synchronized input clock edge |
| rate_sel | input | 2 | Input rate code: 0 = 2 kHz, 1 = 4 kHz, 2 = 8 kHz, 3 = not low-rate |
| win_en | input | 1 | Enables the noise-window check |
| qualified | output | 1 | 1 when the input is eligible for selection |

## Verification
An edge verdict, whether it accepts or rejects, appears one clock after the cycle that carries the edge strobe. A timeout appears one clock after the tick that takes the count past the upper bound. The bypass for `win_en` and for rate code 3 acts in the same cycle. The bench drives every strobe on the falling edge and samples `qualified` on the falling edge that follows the rising edge that consumed the strobe, so each check lands in the first cycle where the result is due. The bench sweeps the interval length across each window and three ticks beyond it on both sides, for all three rates, and computes the bounds in its own form.

// File: rtl/enq_pkg.sv
package enq_pkg;

  typedef enum logic [1:0] {
    RATE_2K   = 2'd0,
    RATE_4K   = 2'd1,
    RATE_8K   = 2'd2,
    RATE_NONE = 2'd3
  } rate_e;

  localparam int unsigned SLOWEST_HZ = 2000;

  // Nominal period, in reference ticks, for a rate code.
  function automatic int unsigned period_ticks(input logic [1:0] code,
                                               input int unsigned ref_hz);
    case (code)
      2'd0:    return ref_hz / SLOWEST_HZ;
      2'd1:    return ref_hz / (SLOWEST_HZ * 2);
      2'd2:    return ref_hz / (SLOWEST_HZ * 4);
      default: return 0;
    endcase
  endfunction

  // Five-percent margin, rounded down.
  function automatic int unsigned margin(input int unsigned p);
    return p / 20;
  endfunction

  function automatic int unsigned win_lo(input int unsigned p);
    return p - margin(p);
  endfunction

  function automatic int unsigned win_hi(input int unsigned p);
    return p + margin(p);
  endfunction

endpackage

// File: rtl/enq_window.sv
module enq_window #(
  parameter int unsigned REF_HZ = 80000,
  parameter int unsigned CNT_W  = 6
) (
  input  logic [1:0]       rate_sel,
  output logic [CNT_W-1:0] lo,
  output logic [CNT_W-1:0] hi,
  output logic             applies
);
  import enq_pkg::*;

  localparam int unsigned N_RATES = 3;

  logic [CNT_W-1:0] lo_tab [N_RATES];
  logic [CNT_W-1:0] hi_tab [N_RATES];

  for (genvar g = 0; g < N_RATES; g++) begin : g_rate
    localparam int unsigned P = period_ticks(2'(g), REF_HZ);
    assign lo_tab[g] = CNT_W'(win_lo(P));
    assign hi_tab[g] = CNT_W'(win_hi(P));
  end

  always_comb begin
    applies = (rate_sel != RATE_NONE);
    case (rate_sel)
      2'd0:    begin lo = lo_tab[0]; hi = hi_tab[0]; end
      2'd1:    begin lo = lo_tab[1]; hi = hi_tab[1]; end
      2'd2:    begin lo = lo_tab[2]; hi = hi_tab[2]; end
      default: begin lo = '0;        hi = '0;        end
    endcase
  end

endmodule

// File: rtl/enq_interval.sv
module enq_interval #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             ref_tick,
  input  logic             edge_stb,
  input  logic [CNT_W-1:0] hi,
  output logic [CNT_W-1:0] tick_cnt,
  output logic             armed,
  output logic             meas_evt,
  output logic             timeout_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic live;
  assign live = run && !restart;

  // A measured edge closes an interval that a previous edge opened.
  assign meas_evt    = live && armed && edge_stb;
  // The count is about to step past the upper bound with no edge.
  assign timeout_evt = live && armed && !edge_stb && ref_tick && (tick_cnt == hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      armed    <= 1'b0;
    end else if (!live) begin
      tick_cnt <= '0;
      armed    <= 1'b0;
    end else if (edge_stb) begin
      armed    <= 1'b1;
      tick_cnt <= ref_tick ? ONE : '0;
    end else if (armed && ref_tick && (tick_cnt <= hi)) begin
      tick_cnt <= tick_cnt + ONE;
    end
  end

  // R5: every accepted edge restarts the count
  p_edge_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live && edge_stb |=> tick_cnt <= ONE);

  // R6: the count never runs beyond one past the upper bound
  p_cnt_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !restart && run |-> tick_cnt <= hi + ONE);

endmodule

// File: rtl/enq_verdict.sv
module enq_verdict #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] tick_cnt,
  input  logic             meas_evt,
  input  logic             timeout_evt,
  output logic             qual_q
);

  logic in_win;
  assign in_win = (tick_cnt >= lo) && (tick_cnt <= hi);

  always_ff @(posedge clk) begin
    if (!rst_n)           qual_q <= 1'b1;
    else if (!run)        qual_q <= 1'b1;
    else if (meas_evt)    qual_q <= in_win;
    else if (timeout_evt) qual_q <= 1'b0;
  end

  // R3: an out-of-window edge withdraws qualification
  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_evt && !in_win |=> !qual_q);

  // R4: an in-window edge restores qualification
  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_evt && in_win |=> qual_q);

  // R6: a missing edge past the upper bound withdraws qualification
  p_timeout_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !qual_q);

  // R7: with the check off the verdict returns to qualified
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> qual_q);

  // R6: an edge and a timeout never both apply in one cycle
  p_evt_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_evt && timeout_evt));

endmodule

// File: rtl/edge_noise_qualifier.sv
module edge_noise_qualifier #(
  parameter int unsigned REF_TICK_HZ = 80000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       edge_stb,
  input  logic [1:0] rate_sel,
  input  logic       win_en,
  output logic       qualified
);
  import enq_pkg::*;

  localparam int unsigned MAX_P  = REF_TICK_HZ / SLOWEST_HZ;
  localparam int unsigned MAX_HI = MAX_P + MAX_P / 20;
  localparam int unsigned CNT_W  = $clog2(MAX_HI + 2);

  logic [CNT_W-1:0] lo, hi, tick_cnt;
  logic             applies, run, restart;
  logic             armed, meas_evt, timeout_evt, qual_q;
  logic [1:0]       rate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rate_q <= RATE_NONE;
    else        rate_q <= rate_sel;
  end

  assign restart = (rate_sel != rate_q);
  assign run     = win_en && applies;

  enq_window #(.REF_HZ(REF_TICK_HZ), .CNT_W(CNT_W)) u_window (
    .rate_sel (rate_sel),
    .lo       (lo),
    .hi       (hi),
    .applies  (applies)
  );

  enq_interval #(.CNT_W(CNT_W)) u_interval (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .restart     (restart),
    .ref_tick    (ref_tick),
    .edge_stb    (edge_stb),
    .hi          (hi),
    .tick_cnt    (tick_cnt),
    .armed       (armed),
    .meas_evt    (meas_evt),
    .timeout_evt (timeout_evt)
  );

  enq_verdict #(.CNT_W(CNT_W)) u_verdict (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .lo          (lo),
    .hi          (hi),
    .tick_cnt    (tick_cnt),
    .meas_evt    (meas_evt),
    .timeout_evt (timeout_evt),
    .qual_q      (qual_q)
  );

  assign qualified = !run || qual_q;

  // R8: the edge that opens a measurement leaves the verdict alone
  p_first_edge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run && edge_stb && !armed |=> $stable(qual_q));

  // R8: a change of rate stops any running measurement
  p_rate_change_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !armed);

  // R9: a rate code with no low-rate clock never drives the output low
  p_not_low_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rate_sel == RATE_NONE |-> qualified);

endmodule

// File: tb/tb_edge_noise_qualifier.sv
module tb_edge_noise_qualifier;

  localparam int CLK_PERIOD = 10;
  localparam int REF_HZ     = 80000;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       edge_stb = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       win_en = 1'b1;
  logic       qualified;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  edge_noise_qualifier #(.REF_TICK_HZ(REF_HZ)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .edge_stb  (edge_stb),
    .rate_sel  (rate_sel),
    .win_en    (win_en),
    .qualified (qualified)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt >= WATCHDOG) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected fewer than %0d", cyc_cnt, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Bench view of the window: period from the slowest rate by shifting,
  // bounds written as ceil(0.95 P) and floor(1.05 P).
  function automatic int per_of(int r);
    return (REF_HZ / 2000) >> r;
  endfunction
  function automatic int lo_of(int r);
    return (19 * per_of(r) + 19) / 20;
  endfunction
  function automatic int hi_of(int r);
    return (21 * per_of(r)) / 20;
  endfunction

  task automatic cyc(input logic tk, input logic ed);
    @(negedge clk);
    ref_tick = tk;
    edge_stb = ed;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b0);
    end
  endtask

  task automatic edge_now();
    cyc(1'b0, 1'b1);
  endtask

  task automatic interval(input int n);
    ticks(n);
    edge_now();
  endtask

  task automatic check(input string tag, input logic exp, input string what);
    @(negedge clk);
    ref_tick = 1'b0;
    edge_stb = 1'b0;
    n_cmp++;
    if (qualified !== exp) begin
      n_bad++;
      $display("FAIL %s %s: qualified=%0b expected %0b", tag, what, qualified, exp);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check("R1", 1'b1, "state after reset");

    // R8: the first edge after reset only opens a measurement
    edge_now();
    check("R8", 1'b1, "first edge after reset");

    // R2 R3 R4: sweep each window and three ticks beyond it
    for (int r = 0; r < 3; r++) begin
      win_en = 1'b0;
      check("R7", 1'b1, "disabled before rate sweep");
      win_en = 1'b1;
      rate_sel = 2'(r);
      edge_now();
      check("R8", 1'b1, "opening edge of sweep");
      for (int n = lo_of(r) - 3; n <= hi_of(r) + 3; n++) begin
        interval(per_of(r));
        check("R4", 1'b1, "nominal interval");
        interval(n);
        check((n >= lo_of(r) && n <= hi_of(r)) ? "R2 R4" : "R2 R3",
              (n >= lo_of(r) && n <= hi_of(r)), $sformatf("rate %0d len %0d", r, n));
      end
    end

    // R6: timeout at 4 kHz
    rate_sel = 2'd1;
    edge_now();
    interval(per_of(1));
    check("R4", 1'b1, "nominal before timeout");
    ticks(hi_of(1));
    check("R6", 1'b1, "count at upper bound");
    cyc(1'b1, 1'b0);
    check("R6", 1'b0, "tick past upper bound");
    ticks(5);
    edge_now();
    check("R6", 1'b0, "late edge after timeout");
    interval(per_of(1));
    check("R6", 1'b1, "requalified after timeout");

    // R5: a tick coinciding with an edge belongs to the new interval (8 kHz, window [10,10])
    rate_sel = 2'd2;
    edge_now();
    interval(per_of(2));
    check("R4", 1'b1, "nominal at 8 kHz");
    ticks(per_of(2) - 1);
    cyc(1'b1, 1'b1);
    check("R5", 1'b0, "coincident tick excluded from old interval");
    interval(per_of(2));
    check("R5", 1'b0, "coincident tick counted in new interval");
    ticks(per_of(2) - 1);
    cyc(1'b1, 1'b1);
    check("R5", 1'b0, "second coincident edge");
    interval(per_of(2) - 1);
    check("R5", 1'b1, "interval completed by coincident tick");

    // R7: disable forces qualified, re-enable rearms
    rate_sel = 2'd1;
    edge_now();
    interval(2);
    check("R3", 1'b0, "short interval at 4 kHz");
    win_en = 1'b0;
    check("R7", 1'b1, "disable forces qualified");
    interval(2);
    check("R7", 1'b1, "bad interval while disabled");
    win_en = 1'b1;
    edge_now();
    check("R8", 1'b1, "first edge after enable");
    interval(2);
    check("R3", 1'b0, "bad interval after enable");

    // R8: a rate change keeps the verdict until a full interval
    rate_sel = 2'd2;
    edge_now();
    check("R8", 1'b0, "first edge after rate change");
    interval(per_of(2));
    check("R4", 1'b1, "good interval after rate change");

    // R9: code 3 never withdraws qualification
    interval(1);
    check("R3", 1'b0, "bad interval before code 3");
    rate_sel = 2'd3;
    check("R9", 1'b1, "code 3 forces qualified");
    interval(1);
    interval(60);
    check("R9", 1'b1, "edges under code 3");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule